// File: doc/BRIEF.md
# Programmable Down-Counter Timer

This block is one 32-bit timer that counts down. A word-addressed register port sets it up, and it raises one level interrupt when the count runs out. Software writes a reload value and a control word. The count then drops by one on each qualified tick. A tick is qualified when the tick enable input is high and the prescaler, set to divide by 1, 16 or 256, reaches its terminal value.

When the count reaches zero, a raw interrupt flag is latched. The interrupt enable bit masks that flag onto the output pin.

There are three counting modes. In free-running mode the timer reloads with all ones at the selected width. In periodic mode it reloads from the programmed value. In one-shot mode it holds at zero until the next load. The reload value has two write paths. The foreground path restarts the count at once. The background path only updates the value used at the next reload.

Top module: `countdown_timer`

## Requirements
- R1: After reset the control register reads 0x20, so interrupts are enabled and the timer is disabled. The count, the reload value and the raw flag all read zero.
- R2: The word offsets are: 0 foreground reload, 1 count value, 2 control, 3 interrupt clear, 4 raw status, 5 masked status, 6 background reload. Control bits are: 0 one-shot, 1 wide (32-bit), [3:2] prescale, 5 interrupt enable, 6 periodic, 7 enable. Control reads back what was written in those bits, and bit 4 and bits [31:8] read as zero.
- R3: A write to offset 0 sets the reload value. It also sets the count to the written data, masked to the active width, on the next clock edge.
- R4: A write to offset 6 changes only the reload value. The running count is untouched, and the new value is used at the next reload.
- R5: Each qualified tick lowers a nonzero count by one. The step that takes the count from 1 to 0 sets the raw flag (status bit 0 at offset 4). In periodic mode, a qualified tick at zero reloads the masked reload value.
- R6: In one-shot mode (bit 0 set), the count stays at zero on further ticks until offset 0 is written.
- R7: With bits 0 and 6 both clear, a qualified tick at zero reloads 0xFFFF in 16-bit mode and 0xFFFFFFFF in 32-bit mode.
- R8: With bit 1 clear, only the low 16 bits of a load are counted. The upper 16 bits of the value read at offset 1 are zero.
- R9: Prescale code 01 takes one count step per 16 enabled ticks, and code 10 one step per 256. Codes 00 and 11 take one step per tick. The prescaler restarts on a write to offset 0.
- R10: The masked status at offset 5 and the interrupt output both equal the raw flag ANDed with control bit 5.
- R11: Any write to offset 3 clears the raw flag. A write to offset 1 changes neither the count nor the reload value.
- R12: Offsets 0 and 6 both read the reload value, and offset 7 reads zero. With enable (bit 7) clear, ticks do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Input tick qualifier for the prescaler |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Word offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| irqOut | output | 1 | Masked level interrupt |

## Verification
The bench sweeps several reload values through more than two periods. It catches a period that is off by one, and a raw flag set at the reload step instead of the step that reaches zero. One-shot runs show a design that wrongly reloads after expiry. Free-running runs at both widths show a wrong all-ones value, or upper bits leaking into the count in 16-bit mode. Further runs catch a background write that restarts the count, a prescaler that divides at 15 or 255, a masked status that ignores the enable bit, and a count write that is not ignored.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_LOAD   = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_VALUE  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_CLEAR  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_RAW    = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_MASKED = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_BGLOAD = 3'd6;

  localparam int BIT_ONESHOT  = 0;
  localparam int BIT_WIDE     = 1;
  localparam int BIT_PRESC_LO = 2;
  localparam int BIT_IE       = 5;
  localparam int BIT_PERIODIC = 6;
  localparam int BIT_ENABLE   = 7;

  localparam logic [7:0] CTRL_RESET = 8'h20;
  localparam logic [7:0] CTRL_KEEP  = 8'hEF;

  typedef struct packed {
    logic       loadWr;
    logic       bgWr;
    logic       intClr;
    logic       enable;
    logic       oneShot;
    logic       periodic;
    logic       wide;
    logic [1:0] presc;
  } tmrCmd_t;
endpackage

// File: rtl/cdt_datapath.sv
module cdt_datapath
  import cdt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PRESC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  tmrCmd_t          cmd,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countQ,
  output logic [CNT_W-1:0] reloadQ,
  output logic             rawQ
);
  localparam int HALF_W   = CNT_W / 2;
  localparam int FINE_W   = PRESC_W / 2;
  localparam logic [CNT_W-1:0] ONE_VAL = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0]   widthMask;
  logic [CNT_W-1:0]   effCount;
  logic [CNT_W-1:0]   reloadSel;
  logic [PRESC_W-1:0] prescQ;
  logic               prescHit;
  logic               step;

  always_comb begin
    widthMask = cmd.wide ? {CNT_W{1'b1}} : {{(CNT_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    effCount  = countQ & widthMask;
    reloadSel = (cmd.periodic || cmd.oneShot) ? (reloadQ & widthMask) : widthMask;
    case (cmd.presc)
      2'b01:   prescHit = (prescQ[FINE_W-1:0] == {FINE_W{1'b1}});
      2'b10:   prescHit = (prescQ == {PRESC_W{1'b1}});
      default: prescHit = 1'b1;
    endcase
    step = cmd.enable && tickEn && prescHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescQ <= '0;
    end else if (cmd.loadWr) begin
      prescQ <= '0;
    end else if (cmd.enable && tickEn) begin
      prescQ <= prescQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadQ <= '0;
    end else if (cmd.loadWr || cmd.bgWr) begin
      reloadQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (cmd.loadWr) begin
      countQ <= wrData & widthMask;
    end else if (step) begin
      if (effCount != '0) begin
        countQ <= effCount - 1'b1;
      end else if (!cmd.oneShot) begin
        countQ <= reloadSel;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ <= 1'b0;
    end else if (step && !cmd.loadWr && (effCount == ONE_VAL)) begin
      rawQ <= 1'b1;
    end else if (cmd.intClr) begin
      rawQ <= 1'b0;
    end
  end
endmodule

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  input  logic [CNT_W-1:0]  countQ,
  input  logic [CNT_W-1:0]  reloadQ,
  input  logic              rawQ,
  output tmrCmd_t           cmd,
  output logic [7:0]        ctrlQ,
  output logic [CNT_W-1:0]  regRdData,
  output logic              irqOut
);
  localparam int HALF_W = CNT_W / 2;

  logic [CNT_W-1:0] readMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= CTRL_RESET;
    end else if (regWrEn && regAddr == OFS_CTRL) begin
      ctrlQ <= regWrData[7:0] & CTRL_KEEP;
    end
  end

  always_comb begin
    cmd.loadWr   = regWrEn && (regAddr == OFS_LOAD);
    cmd.bgWr     = regWrEn && (regAddr == OFS_BGLOAD);
    cmd.intClr   = regWrEn && (regAddr == OFS_CLEAR);
    cmd.enable   = ctrlQ[BIT_ENABLE];
    cmd.oneShot  = ctrlQ[BIT_ONESHOT];
    cmd.periodic = ctrlQ[BIT_PERIODIC];
    cmd.wide     = ctrlQ[BIT_WIDE];
    cmd.presc    = ctrlQ[BIT_PRESC_LO +: 2];
  end

  always_comb begin
    readMask = ctrlQ[BIT_WIDE] ? {CNT_W{1'b1}} : {{(CNT_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    regRdData = '0;
    case (regAddr)
      OFS_LOAD, OFS_BGLOAD: regRdData = reloadQ;
      OFS_VALUE:  regRdData = countQ & readMask;
      OFS_CTRL:   regRdData = {{(CNT_W-8){1'b0}}, ctrlQ};
      OFS_RAW:    regRdData = {{(CNT_W-1){1'b0}}, rawQ};
      OFS_MASKED: regRdData = {{(CNT_W-1){1'b0}}, rawQ & ctrlQ[BIT_IE]};
      default:    regRdData = '0;
    endcase
  end

  assign irqOut = rawQ & ctrlQ[BIT_IE];
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PRESC_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  regRdData,
  output logic              irqOut
);
  tmrCmd_t          cmd;
  logic [7:0]       ctrlBits;
  logic [CNT_W-1:0] countVal;
  logic [CNT_W-1:0] reloadVal;
  logic             rawFlag;

  cdt_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .countQ    (countVal),
    .reloadQ   (reloadVal),
    .rawQ      (rawFlag),
    .cmd       (cmd),
    .ctrlQ     (ctrlBits),
    .regRdData (regRdData),
    .irqOut    (irqOut)
  );

  cdt_datapath #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .cmd     (cmd),
    .wrData  (regWrData),
    .countQ  (countVal),
    .reloadQ (reloadVal),
    .rawQ    (rawFlag)
  );
endmodule

// File: rtl/countdown_timer_chk.sv
module countdown_timer_chk
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [CNT_W-1:0]  regWrData,
  input logic [CNT_W-1:0]  regRdData,
  input logic              irqOut,
  input logic [CNT_W-1:0]  countVal,
  input logic              rawFlag,
  input logic [7:0]        ctrlBits
);
  assert_irq_matches_masked_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == OFS_MASKED) |-> (regRdData[0] == irqOut));

  assert_load_restarts_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFS_LOAD && ctrlBits[BIT_WIDE]) |=> (countVal == $past(regWrData)));

  assert_bgload_keeps_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFS_BGLOAD && !tickEn) |=> $stable(countVal));

  assert_clear_drops_raw_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFS_CLEAR && !tickEn) |=> !rawFlag);

  assert_oneshot_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBits[BIT_ONESHOT] && countVal == '0 && !(regWrEn && regAddr == OFS_LOAD))
      |=> (countVal == '0));

  assert_disabled_frozen_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlBits[BIT_ENABLE] && !(regWrEn && regAddr == OFS_LOAD)) |=> $stable(countVal));
endmodule

bind countdown_timer countdown_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .tickEn    (tickEn),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .irqOut    (irqOut),
  .countVal  (countVal),
  .rawFlag   (rawFlag),
  .ctrlBits  (ctrlBits)
);

// File: tb/countdown_timer_tb_top.sv
module countdown_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  countdown_timer dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqOut    (irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic tick(input int n);
    if (n > 0) begin
      @(negedge clk);
      tickEn = 1'b1;
      repeat (n) @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  initial begin
    logic [31:0] v;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(3'd2, v); chk("R1 ctrl", v, 32'h20);
    rd(3'd1, v); chk("R1 count", v, 0);
    rd(3'd0, v); chk("R1 reload", v, 0);
    rd(3'd4, v); chk("R1 raw", v, 0);
    chk("R1 irq", {31'd0, irqOut}, 0);

    // R2 control readback, bit 4 dropped
    wr(3'd2, 32'hFFFF_FF7F); rd(3'd2, v); chk("R2 ctrl readback", v, 32'h6F);

    // R5 periodic sweep over several reloads, wide, div1
    for (int ld = 1; ld <= 5; ld++) begin
      int m;
      bit raw;
      wr(3'd2, 32'h62);
      wr(3'd0, ld);
      wr(3'd3, 0);
      wr(3'd2, 32'hE2);
      rd(3'd1, v); chk("R3 load value", v, ld);
      m = ld; raw = 0;
      for (int i = 0; i < 2 * (ld + 1) + 1; i++) begin
        tick(1);
        if (m != 0) begin m--; if (m == 0) raw = 1; end
        else m = ld;
        rd(3'd1, v); chk("R5 periodic count", v, m);
        rd(3'd4, v); chk("R5 raw flag", v, {31'd0, raw});
      end
    end

    // R10 masked status and irq
    rd(3'd5, v); chk("R10 masked with ie", v, 1);
    chk("R10 irq with ie", {31'd0, irqOut}, 1);
    wr(3'd2, 32'h42);
    rd(3'd5, v); chk("R10 masked no ie", v, 0);
    rd(3'd4, v); chk("R10 raw kept", v, 1);
    chk("R10 irq no ie", {31'd0, irqOut}, 0);
    // R11 clear
    wr(3'd2, 32'h22);
    wr(3'd3, 32'h1234);
    rd(3'd4, v); chk("R11 raw cleared", v, 0);
    chk("R11 irq cleared", {31'd0, irqOut}, 0);

    // R6 one-shot
    wr(3'd2, 32'h23); wr(3'd0, 3); wr(3'd2, 32'hA3);
    tick(3);
    rd(3'd1, v); chk("R6 oneshot reached zero", v, 0);
    rd(3'd4, v); chk("R6 oneshot raw", v, 1);
    tick(10);
    rd(3'd1, v); chk("R6 oneshot holds", v, 0);
    wr(3'd0, 2);
    rd(3'd1, v); chk("R6 reload after load", v, 2);
    wr(3'd3, 0);

    // R7 R8 free-running 16-bit
    wr(3'd2, 32'h20); wr(3'd0, 32'h1234_0002); wr(3'd2, 32'hA0);
    rd(3'd1, v); chk("R8 low half only", v, 32'h0002);
    tick(2);
    rd(3'd1, v); chk("R7 free16 zero", v, 0);
    tick(1);
    rd(3'd1, v); chk("R7 free16 wrap", v, 32'hFFFF);
    tick(1);
    rd(3'd1, v); chk("R8 free16 next", v, 32'hFFFE);

    // R7 free-running 32-bit
    wr(3'd2, 32'h22); wr(3'd0, 1); wr(3'd2, 32'hA2);
    tick(1);
    rd(3'd1, v); chk("R7 free32 zero", v, 0);
    tick(1);
    rd(3'd1, v); chk("R7 free32 wrap", v, 32'hFFFF_FFFF);

    // R4 background reload
    wr(3'd2, 32'h62); wr(3'd0, 2); wr(3'd2, 32'hE2);
    wr(3'd6, 7);
    rd(3'd1, v); chk("R4 count untouched", v, 2);
    rd(3'd0, v); chk("R12 load reads reload", v, 7);
    rd(3'd6, v); chk("R12 bgload reads reload", v, 7);
    tick(2);
    rd(3'd1, v); chk("R4 old count reaches zero", v, 0);
    tick(1);
    rd(3'd1, v); chk("R4 new reload used", v, 7);

    // R9 prescale by 16 and 256, plus code 11
    wr(3'd2, 32'hE6); wr(3'd0, 10);
    tick(15); rd(3'd1, v); chk("R9 div16 before", v, 10);
    tick(1);  rd(3'd1, v); chk("R9 div16 step", v, 9);
    tick(16); rd(3'd1, v); chk("R9 div16 second step", v, 8);
    wr(3'd2, 32'hEA); wr(3'd0, 10);
    tick(255); rd(3'd1, v); chk("R9 div256 before", v, 10);
    tick(1);   rd(3'd1, v); chk("R9 div256 step", v, 9);
    wr(3'd2, 32'hEE); wr(3'd0, 10);
    tick(1); rd(3'd1, v); chk("R9 code11 div1", v, 9);

    // R12 disabled freezes count
    wr(3'd2, 32'h62); wr(3'd0, 5);
    tick(20); rd(3'd1, v); chk("R12 disabled frozen", v, 5);

    // R11 value write ignored
    wr(3'd1, 32'd99);
    rd(3'd1, v); chk("R11 value write ignored count", v, 5);
    rd(3'd0, v); chk("R11 value write ignored reload", v, 5);

    // R12 unmapped and write-only reads
    rd(3'd7, v); chk("R12 unmapped zero", v, 0);
    rd(3'd3, v); chk("R2 clear offset reads zero", v, 0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule